// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block maps a 32-bit effective address to a physical address using 32 translation entries that are all searched at once. Each lookup supplies the effective address, an address-space bit, the current 8-bit process ID, an access kind (read, write or execute) and a supervisor/user mode flag. The block answers combinationally in the same cycle. It returns a hit flag, a multi-match flag, the physical address, the memory attribute bits of the selected entry and a permission-fault flag.

Each entry has its own page size, from 4 KB up to 256 MB in steps of four. The size sets how many low page-number bits are excluded from the compare. The same bits are copied from the effective address into the physical address. An entry whose translation ID is zero is shared by every process. Software-style maintenance goes through a 71-bit staging register. A write-entry command copies the staging register into the indexed entry. A read-entry command copies the indexed entry into the staging register. A separate command invalidates every entry that is not protected.

Top module: `xlat_cam`

## Requirements
- R1: After synchronous reset every entry is invalid, no lookup hits, and the staging register reads zero.
- R2: When `stage_load` is high and `cmd_read` is low, the staging register takes `stage_din` at the next clock edge. The entry layout, from the MSB down, is: valid[70], space[69], tid[68:61], epn[60:41], rpn[40:21], size[20:17], perms {sx,sw,sr,ux,uw,ur}[16:11], wimge[10:6], user[5:2], protect[1], alt-code[0].
- R3: When `cmd_write` is high, entry `cmd_idx` takes the staging register's value at the next edge. A write has priority over an invalidate-all issued in the same cycle.
- R4: When `cmd_read` is high, the staging register takes entry `cmd_idx` at the next edge. A read has priority over `stage_load`.
- R5: An entry can match only if it is valid, its space bit equals `lk_as`, and its epn equals `lk_ea[31:12]` on the compared bits.
- R6: An entry also needs a tid equal to `lk_pid` or a tid of zero. A zero tid matches every process ID.
- R7: Size code n from 1 to 9 gives a page of 4^(n-1) × 4 KB. The compare then ignores the low 2·(n-1) page-number bits. Codes 0 and 10 to 15 never match.
- R8: On a hit, `pa` combines the rpn on the compared bits with `lk_ea` on the ignored page bits and `lk_ea[11:0]`. On a miss, `pa` is zero.
- R9: If two or more entries match, `multi_hit` is high and the lowest-numbered matching entry supplies every result.
- R10: `lk_kind` encodes read=0, write=1, execute=2. On a hit, `perm_fault` is high when the permission bit for that kind in the current mode (sr/sw/sx for supervisor, ur/uw/ux for user) is clear. Kind 3 always faults on a hit. On a miss, `perm_fault` is low.
- R11: On a hit, `attr_wimge`, `attr_user` and `attr_code_alt` carry the selected entry's fields. On a miss they are zero.
- R12: `inv_all` clears the valid bit of every entry whose protect bit is clear at the next edge. Protected entries keep working.
- R13: Lookup outputs depend only on the current lookup inputs and the stored entries, and are valid in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_ea | input | 32 | Effective address to translate |
| lk_as | input | 1 | Address-space bit of the access |
| lk_pid | input | 8 | Current process ID |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| hit | output | 1 | At least one entry matched |
| multi_hit | output | 1 | More than one entry matched |
| pa | output | 32 | Physical address |
| attr_wimge | output | 5 | Memory attribute bits of the selected entry |
| attr_user | output | 4 | Software user bits of the selected entry |
| attr_code_alt | output | 1 | Alternate code-format page flag |
| perm_fault | output | 1 | Access not permitted by the selected entry |
| stage_load | input | 1 | Load `stage_din` into the staging register |
| stage_din | input | 71 | Staging register write data |
| stage_dout | output | 71 | Staging register contents |
| cmd_write | input | 1 | Copy the staging register into entry `cmd_idx` |
| cmd_read | input | 1 | Copy entry `cmd_idx` into the staging register |
| cmd_idx | input | 5 | Entry index for write and read commands |
| inv_all | input | 1 | Invalidate all unprotected entries |

## Verification
The lookup outputs `hit`, `multi_hit`, `pa`, the attribute outputs and `perm_fault` are due in the same cycle as the request. The driver applies each lookup just after a falling edge and pushes its expected result. The monitor compares the result 1 ns later, before the next rising edge can change any entry. Staging, write, read and invalidate effects take one rising edge. Their checks sample at the falling edge after the command cycle's rising edge. A write is observed either through a later lookup or by reading the entry back into `stage_dout`.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W       = 32;
    localparam int PG_SHIFT   = 12;
    localparam int PN_W       = VA_W - PG_SHIFT;
    localparam int TID_W      = 8;
    localparam int SZ_W       = 4;
    localparam int NUM_ENT    = 32;
    localparam int IDX_W      = $clog2(NUM_ENT);
    localparam int MAX_SZ     = 9;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_BAD = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic sx;
        logic sw;
        logic sr;
        logic ux;
        logic uw;
        logic ur;
    } perm_t;

    typedef struct packed {
        logic               valid;
        logic               space;
        logic [TID_W-1:0]   tid;
        logic [PN_W-1:0]    epn;
        logic [PN_W-1:0]    rpn;
        logic [SZ_W-1:0]    size;
        perm_t              perm;
        logic [4:0]         wimge;
        logic [3:0]         ubits;
        logic               protect;
        logic               code_alt;
    } xent_t;

    localparam int ENT_W = $bits(xent_t);

    typedef struct packed {
        logic               valid;
        logic               space;
        logic [TID_W-1:0]   tid;
        logic [PN_W-1:0]    epn;
        logic [SZ_W-1:0]    size;
    } xkey_t;

    // page-number bits that take part in the compare for a size code
    function automatic logic [PN_W-1:0] keep_mask(input logic [SZ_W-1:0] sz);
        logic [PN_W-1:0] m;
        int unsigned     drop;
        drop = (sz == '0) ? 0 : 2 * (int'(sz) - 1);
        m = '1;
        for (int k = 0; k < PN_W; k++) begin
            if (k < int'(drop)) m[k] = 1'b0;
        end
        return m;
    endfunction

    function automatic logic size_legal(input logic [SZ_W-1:0] sz);
        return (sz != '0) && (int'(sz) <= MAX_SZ);
    endfunction

    function automatic logic perm_ok(input perm_t p, input acc_kind_e k, input logic sup);
        logic ok;
        case (k)
            ACC_RD:  ok = sup ? p.sr : p.ur;
            ACC_WR:  ok = sup ? p.sw : p.uw;
            ACC_EX:  ok = sup ? p.sx : p.ux;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  xent_t                wr_ent,
    input  logic                 inv_all,
    output xent_t                rd_ent,
    output xent_t [NUM_ENT-1:0]  ents
);
    xent_t [NUM_ENT-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            if (inv_all) begin
                for (int i = 0; i < NUM_ENT; i++) begin
                    if (!mem_q[i].protect) mem_q[i].valid <= 1'b0;
                end
            end
            if (wr_en) mem_q[idx] <= wr_ent;
        end
    end

    assign rd_ent = mem_q[idx];
    assign ents   = mem_q;
endmodule

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
(
    input  xkey_t [NUM_ENT-1:0] keys,
    input  logic [PN_W-1:0]     pn,
    input  logic                as_bit,
    input  logic [TID_W-1:0]    pid,
    output logic [NUM_ENT-1:0]  hit_vec
);
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        logic [PN_W-1:0] m;
        logic            pn_eq;
        logic            id_ok;
        assign m       = keep_mask(keys[g].size);
        assign pn_eq   = ((keys[g].epn ^ pn) & m) == '0;
        assign id_ok   = (keys[g].tid == pid) || (keys[g].tid == '0);
        assign hit_vec[g] = keys[g].valid && (keys[g].space == as_bit) &&
                            size_legal(keys[g].size) && pn_eq && id_ok;
    end
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
    import xlat_pkg::*;
(
    input  logic [NUM_ENT-1:0] hit_vec,
    output logic               any,
    output logic               many,
    output logic [IDX_W-1:0]   sel
);
    always_comb begin
        sel = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IDX_W'(i);
        end
    end

    assign any  = |hit_vec;
    assign many = (hit_vec & (hit_vec - 1'b1)) != '0;
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VA_W-1:0]      lk_ea,
    input  logic                 lk_as,
    input  logic [TID_W-1:0]     lk_pid,
    input  logic [1:0]           lk_kind,
    input  logic                 lk_super,
    output logic                 hit,
    output logic                 multi_hit,
    output logic [VA_W-1:0]      pa,
    output logic [4:0]           attr_wimge,
    output logic [3:0]           attr_user,
    output logic                 attr_code_alt,
    output logic                 perm_fault,
    input  logic                 stage_load,
    input  logic [ENT_W-1:0]     stage_din,
    output logic [ENT_W-1:0]     stage_dout,
    input  logic                 cmd_write,
    input  logic                 cmd_read,
    input  logic [IDX_W-1:0]     cmd_idx,
    input  logic                 inv_all
);
    xent_t                stage_q;
    xent_t                rd_ent;
    xent_t [NUM_ENT-1:0]  ents;
    xkey_t [NUM_ENT-1:0]  keys;
    logic [NUM_ENT-1:0]   hv;
    logic [NUM_ENT-1:0]   vld_vec;
    logic [NUM_ENT-1:0]   prot_vec;
    logic                 any_hit;
    logic                 many_hit;
    logic [IDX_W-1:0]     sel;
    xent_t                pick;
    logic [PN_W-1:0]      km;

    always_ff @(posedge clk) begin
        if (rst)             stage_q <= '0;
        else if (cmd_read)   stage_q <= rd_ent;
        else if (stage_load) stage_q <= xent_t'(stage_din);
    end
    assign stage_dout = stage_q;

    xlat_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd_write),
        .idx     (cmd_idx),
        .wr_ent  (stage_q),
        .inv_all (inv_all),
        .rd_ent  (rd_ent),
        .ents    (ents)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_key
        assign keys[g]     = '{valid: ents[g].valid, space: ents[g].space,
                               tid: ents[g].tid, epn: ents[g].epn, size: ents[g].size};
        assign vld_vec[g]  = ents[g].valid;
        assign prot_vec[g] = ents[g].protect;
    end

    xlat_match u_match (
        .keys    (keys),
        .pn      (lk_ea[VA_W-1:PG_SHIFT]),
        .as_bit  (lk_as),
        .pid     (lk_pid),
        .hit_vec (hv)
    );

    xlat_pick u_pick (
        .hit_vec (hv),
        .any     (any_hit),
        .many    (many_hit),
        .sel     (sel)
    );

    assign pick = ents[sel];
    assign km   = keep_mask(pick.size);

    always_comb begin
        hit           = any_hit;
        multi_hit     = many_hit;
        pa            = '0;
        attr_wimge    = '0;
        attr_user     = '0;
        attr_code_alt = 1'b0;
        perm_fault    = 1'b0;
        if (any_hit) begin
            pa            = {(pick.rpn & km) | (lk_ea[VA_W-1:PG_SHIFT] & ~km),
                             lk_ea[PG_SHIFT-1:0]};
            attr_wimge    = pick.wimge;
            attr_user     = pick.ubits;
            attr_code_alt = pick.code_alt;
            perm_fault    = !perm_ok(pick.perm, acc_kind_e'(lk_kind), lk_super);
        end
    end
endmodule

// File: rtl/xlat_cam_chk.sv
module xlat_cam_chk
    import xlat_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                hit,
    input logic                multi_hit,
    input logic                perm_fault,
    input logic                stage_load,
    input logic                cmd_read,
    input logic                cmd_write,
    input logic                inv_all,
    input logic [ENT_W-1:0]    stage_din,
    input logic [ENT_W-1:0]    stage_dout,
    input logic [NUM_ENT-1:0]  vld_vec,
    input logic [NUM_ENT-1:0]  prot_vec
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vld_vec == '0 && stage_dout == '0));

    // R2
    stage_load_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_load && !cmd_read) |=> (stage_dout == $past(stage_din)));

    // R5
    no_valid_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_vec == '0) |-> !hit);

    // R9
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> hit);

    // R10
    fault_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        perm_fault |-> hit);

    // R12
    inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_all && !cmd_write) |=> ((vld_vec & ~prot_vec) == '0));
endmodule

bind xlat_cam xlat_cam_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .multi_hit  (multi_hit),
    .perm_fault (perm_fault),
    .stage_load (stage_load),
    .cmd_read   (cmd_read),
    .cmd_write  (cmd_write),
    .inv_all    (inv_all),
    .stage_din  (stage_din),
    .stage_dout (stage_dout),
    .vld_vec    (vld_vec),
    .prot_vec   (prot_vec)
);

// File: tb/tb_xlat_cam.sv
`timescale 1ns/1ps
module tb_xlat_cam;
    import xlat_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [31:0]      lk_ea = '0;
    logic             lk_as = 1'b0;
    logic [7:0]       lk_pid = '0;
    logic [1:0]       lk_kind = '0;
    logic             lk_super = 1'b0;
    logic             hit, multi_hit, attr_code_alt, perm_fault;
    logic [31:0]      pa;
    logic [4:0]       attr_wimge;
    logic [3:0]       attr_user;
    logic             stage_load = 1'b0;
    logic [ENT_W-1:0] stage_din = '0;
    logic [ENT_W-1:0] stage_dout;
    logic             cmd_write = 1'b0, cmd_read = 1'b0, inv_all = 1'b0;
    logic [4:0]       cmd_idx = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xlat_cam dut (.*);

    typedef struct {
        logic        h;
        logic        m;
        logic [31:0] a;
        logic [4:0]  w;
        logic        ca;
        logic        f;
        string       tag;
    } exp_t;

    exp_t q[$];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ENT_W-1:0] mk(input logic v, input logic ts, input logic [7:0] tid,
        input logic [19:0] epn, input logic [19:0] rpn, input logic [3:0] sz, input logic [5:0] pm,
        input logic [4:0] w, input logic [3:0] ub, input logic pr, input logic ca);
        return {v, ts, tid, epn, rpn, sz, pm, w, ub, pr, ca};
    endfunction

    // driver: apply a lookup after a falling edge and push the expected result
    task automatic look(input logic [31:0] ea, input logic as_, input logic [7:0] pid,
        input logic [1:0] kind, input logic sup, input logic eh, input logic em,
        input logic [31:0] ea_exp, input logic [4:0] ew, input logic eca, input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        lk_ea = ea; lk_as = as_; lk_pid = pid; lk_kind = kind; lk_super = sup;
        e.h = eh; e.m = em; e.a = ea_exp; e.w = ew; e.ca = eca; e.f = ef; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: results are combinational, due in the request cycle
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(hit == e.h, {e.tag, " hit"}, 128'(hit), 128'(e.h));
                chk(multi_hit == e.m, {e.tag, " multi"}, 128'(multi_hit), 128'(e.m));
                chk(pa == e.a, {e.tag, " pa"}, 128'(pa), 128'(e.a));
                chk(attr_wimge == e.w, {e.tag, " wimge"}, 128'(attr_wimge), 128'(e.w));
                chk(attr_code_alt == e.ca, {e.tag, " alt"}, 128'(attr_code_alt), 128'(e.ca));
                chk(perm_fault == e.f, {e.tag, " fault"}, 128'(perm_fault), 128'(e.f));
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic [4:0] idx, input logic [ENT_W-1:0] ent);
        @(negedge clk);
        stage_load = 1'b1; stage_din = ent;
        @(negedge clk);
        stage_load = 1'b0;
        chk(stage_dout == ent, "R2 staging load", 128'(stage_dout), 128'(ent));
        cmd_write = 1'b1; cmd_idx = idx;
        @(negedge clk);
        cmd_write = 1'b0;
    endtask

    task automatic get(input logic [4:0] idx);
        @(negedge clk);
        cmd_read = 1'b1; cmd_idx = idx;
        @(negedge clk);
        cmd_read = 1'b0;
    endtask

    logic [ENT_W-1:0] e_a, e_b, e_c, e_d, e_bad0, e_bad10;

    initial begin
        // perms {sx,sw,sr,ux,uw,ur}
        e_a = mk(1, 0, 8'h12, 20'h10000, 20'h80000, 4'd1, 6'b111111, 5'b10101, 4'h3, 0, 1);
        e_b = mk(1, 1, 8'h00, 20'h20000, 20'hA0000, 4'd9, 6'b001000, 5'b00010, 4'h0, 1, 0);
        e_c = mk(1, 0, 8'h12, 20'h30040, 20'h55550, 4'd3, 6'b000011, 5'b01000, 4'h0, 0, 0);
        e_d = mk(1, 0, 8'h12, 20'h10000, 20'h90000, 4'd1, 6'b111111, 5'b00001, 4'h0, 0, 0);
        e_bad0  = mk(1, 0, 8'h00, 20'h40000, 20'h11111, 4'd0,  6'b111111, 5'b0, 4'h0, 0, 0);
        e_bad10 = mk(1, 0, 8'h00, 20'h50000, 20'h22222, 4'd10, 6'b111111, 5'b0, 4'h0, 0, 0);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(stage_dout == '0, "R1 staging after reset", 128'(stage_dout), 128'(0));
        look(32'h10000ABC, 0, 8'h12, 2'd0, 1, 0, 0, 32'h0, 5'h0, 0, 0, "R1 no hit after reset");
        drain();

        put(5'd3, e_a);
        put(5'd7, e_b);
        put(5'd10, e_c);

        look(32'h10000ABC, 0, 8'h12, 2'd0, 1, 1, 0, 32'h80000ABC, 5'b10101, 1, 0, "R3 R5 R8 R11 R13 4K hit");
        look(32'h10000ABC, 0, 8'h13, 2'd0, 1, 0, 0, 32'h0, 5'h0, 0, 0, "R6 pid mismatch");
        look(32'h10000ABC, 1, 8'h12, 2'd0, 1, 0, 0, 32'h0, 5'h0, 0, 0, "R5 space mismatch");
        look(32'h2ABCD123, 1, 8'h77, 2'd0, 1, 1, 0, 32'hAABCD123, 5'b00010, 0, 0, "R6 R7 global 256M");
        look(32'h2ABCD123, 1, 8'h77, 2'd0, 0, 1, 0, 32'hAABCD123, 5'b00010, 0, 1, "R10 user read fault");
        look(32'h2ABCD123, 1, 8'h77, 2'd1, 1, 1, 0, 32'hAABCD123, 5'b00010, 0, 1, "R10 sup write fault");
        look(32'h2ABCD123, 1, 8'h77, 2'd3, 1, 1, 0, 32'hAABCD123, 5'b00010, 0, 1, "R10 kind3 fault");
        look(32'h3004F9A0, 0, 8'h12, 2'd1, 0, 1, 0, 32'h5555F9A0, 5'b01000, 0, 0, "R7 R8 64K user write");
        look(32'h3004F9A0, 0, 8'h12, 2'd0, 1, 1, 0, 32'h5555F9A0, 5'b01000, 0, 1, "R10 sup read fault");
        look(32'h3004F9A0, 0, 8'h12, 2'd2, 0, 1, 0, 32'h5555F9A0, 5'b01000, 0, 1, "R10 user exec fault");
        look(32'h30050000, 0, 8'h12, 2'd1, 0, 0, 0, 32'h0, 5'h0, 0, 0, "R7 outside 64K page");
        drain();

        get(5'd7);
        chk(stage_dout == e_b, "R4 read entry 7", 128'(stage_dout), 128'(e_b));
        @(negedge clk);
        cmd_read = 1'b1; cmd_idx = 5'd10; stage_load = 1'b1; stage_din = e_d;
        @(negedge clk);
        cmd_read = 1'b0; stage_load = 1'b0;
        chk(stage_dout == e_c, "R4 read beats stage load", 128'(stage_dout), 128'(e_c));

        put(5'd20, e_d);
        put(5'd25, e_bad0);
        put(5'd26, e_bad10);
        look(32'h10000ABC, 0, 8'h12, 2'd0, 1, 1, 1, 32'h80000ABC, 5'b10101, 1, 0, "R9 lowest index wins");
        look(32'h40000000, 0, 8'h00, 2'd0, 1, 0, 0, 32'h0, 5'h0, 0, 0, "R7 size code 0");
        look(32'h50000000, 0, 8'h00, 2'd0, 1, 0, 0, 32'h0, 5'h0, 0, 0, "R7 size code 10");
        drain();

        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        look(32'h10000ABC, 0, 8'h12, 2'd0, 1, 0, 0, 32'h0, 5'h0, 0, 0, "R12 unprotected gone");
        look(32'h2ABCD123, 1, 8'h05, 2'd0, 1, 1, 0, 32'hAABCD123, 5'b00010, 0, 0, "R12 protected kept");
        drain();
        get(5'd3);
        chk(stage_dout[70] == 1'b0, "R12 entry 3 valid bit", 128'(stage_dout[70]), 128'(0));

        // R3 write beats invalidate in the same cycle
        @(negedge clk);
        stage_load = 1'b1; stage_din = e_a;
        @(negedge clk);
        stage_load = 1'b0; cmd_write = 1'b1; cmd_idx = 5'd4; inv_all = 1'b1;
        @(negedge clk);
        cmd_write = 1'b0; inv_all = 1'b0;
        look(32'h10000ABC, 0, 8'h12, 2'd0, 1, 1, 0, 32'h80000ABC, 5'b10101, 1, 0, "R3 write over invalidate");
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule